// File: doc/BRIEF.md
# IR sample stream packet parser

This block sits behind the receive FIFO of an infrared receiver. It takes the FIFO's byte stream, in which control packets and runs of pulse/space samples are interleaved, and sorts out where each packet begins and ends. A small state machine walks through header, subcommand, command payload and sample run. A fixed size table, indexed by the command and subcommand pair, tells it how many payload bytes to discard.

Each sample byte in a run becomes one event on the output. The event carries a polarity flag and a duration in microseconds, which is the sample's count field times the sample period. A pulse-run header whose length is zero does not start a run. It produces a single reset event, which the downstream protocol decoder uses to drop any partial symbol. Command payload bytes produce no output at all. The input is a valid/ready byte stream. The output is a registered event stream with no back-pressure.

Top module: `ir_packet_parser`

## Requirements
- R1: While reset is asserted, `inReady`, `evValid` and `evReset` are 0. From the first clock edge after reset is released, `inReady` is 1. The first accepted byte is treated as a header.
- R2: In the header state, a byte whose bits 7:5 are 101 and whose bits 4:0 (N) are non-zero starts a run. The next N accepted bytes are samples, and the byte after them is a header.
- R3: Each sample byte produces, one clock after it is accepted, `evValid`=1 for one cycle with `evPulse` = bit 7 and `evDuration` = bits 6:0 × PERIOD_US (50 by default).
- R4: The header byte 0xA0 (a run of length zero) produces `evReset`=1 one clock later and leaves the parser in the header state.
- R5: In the header state, a byte whose bits 7:5 are not 101 is taken as a command. The byte 0x9F is one such command, the command header; 0xFF is the hardware header and 0x00 is the null command. The next accepted byte is its subcommand.
- R6: The payload size is looked up from the command/subcommand pair. The pairs with a payload are:
  - null command 0x00 with subcommand 0xFF: 1 byte.
  - hardware header 0xFF with subcommand 0x0B: 2 bytes.
  - command header 0x9F with subcommand 0x06, 0x0C or 0x15: 2 bytes.
  - command header 0x9F with subcommand 0x01, 0x08 or 0x14: 1 byte.
  - every other pair: 0 bytes.
- R7: Command payload bytes produce no event. The byte after the last payload byte is a header.
- R8: When the subcommand's payload size is 0, the next accepted byte is a header.
- R9: A cycle with `inValid`=0 produces no event and does not change the parser state.
- R10: At most one of `evValid` and `evReset` is high in a cycle. Either one is high only in the cycle after an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte valid |
| inData | input | 8 | Input byte from the receive FIFO |
| inReady | output | 1 | Parser accepts a byte this cycle |
| evValid | output | 1 | Sample event strobe |
| evPulse | output | 1 | Event polarity, 1 = pulse, 0 = space |
| evDuration | output | 16 | Event duration in microseconds |
| evReset | output | 1 | Reset event strobe (zero-length run) |

## Verification
If the parser is in the wrong state or holds a wrong remaining count, it misreads packet boundaries. The effect then shows at the ports in one of two ways. Payload bytes can surface as sample events, or samples can be swallowed as payload. Either way the first affected byte shows the error on the very next cycle. A header byte that is misclassified may instead emit a false reset event or miss a real one. The bench therefore feeds long mixed packet streams with idle gaps and compares every cycle's event outputs with an independent byte-level model, so a boundary slip is caught within one byte of where it happens.

// File: rtl/ir_parse_pkg.sv
package ir_parse_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W = 5;

  localparam logic [2:0] RUN_FIELD = 3'b101;
  localparam logic [7:0] CMD_HDR = 8'h9F;
  localparam logic [7:0] HW_HDR = 8'hFF;
  localparam logic [7:0] NULL_CMD = 8'h00;

  localparam logic [7:0] SUB_REVISION = 8'h0B;
  localparam logic [7:0] SUB_CARRIER = 8'h06;
  localparam logic [7:0] SUB_TIMEOUT = 8'h0C;
  localparam logic [7:0] SUB_PULSECNT = 8'h15;
  localparam logic [7:0] SUB_SIGEND = 8'h01;
  localparam logic [7:0] SUB_TXMASK = 8'h08;
  localparam logic [7:0] SUB_RXSENSE = 8'h14;

  typedef enum logic [1:0] {
    ST_HEADER = 2'd0,
    ST_SUBCMD = 2'd1,
    ST_PAYLOAD = 2'd2,
    ST_RUN = 2'd3
  } parseState_t;

  typedef struct packed {
    logic loadCmd;
    logic loadRemHdr;
    logic loadRemSub;
    logic decRem;
    logic emitSample;
    logic emitReset;
  } parseStrobes_t;

  function automatic logic [LEN_W-1:0] payloadLen(input logic [7:0] cmd, input logic [7:0] sub);
    logic [LEN_W-1:0] len;
    len = '0;
    if (cmd == NULL_CMD && sub == HW_HDR) len = LEN_W'(1);
    else if (cmd == HW_HDR && sub == SUB_REVISION) len = LEN_W'(2);
    else if (cmd == CMD_HDR) begin
      case (sub)
        SUB_CARRIER, SUB_TIMEOUT, SUB_PULSECNT: len = LEN_W'(2);
        SUB_SIGEND, SUB_TXMASK, SUB_RXSENSE: len = LEN_W'(1);
        default: len = '0;
      endcase
    end
    return len;
  endfunction
endpackage

// File: rtl/ir_parse_ctrl.sv
module ir_parse_ctrl
  import ir_parse_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic hdrIsRun,
  input  logic hdrLenZero,
  input  logic subSizeZero,
  input  logic remIsOne,
  output logic inReady,
  output parseStrobes_t strb
);
  parseState_t state, nextState;
  logic readyReg;
  logic accept;

  assign inReady = readyReg;
  assign accept = inValid && readyReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_HEADER;
      readyReg <= 1'b0;
    end else begin
      state <= nextState;
      readyReg <= 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    nextState = state;
    if (accept) begin
      case (state)
        ST_HEADER: begin
          if (!hdrIsRun) begin
            strb.loadCmd = 1'b1;
            nextState = ST_SUBCMD;
          end else if (hdrLenZero) begin
            strb.emitReset = 1'b1;
          end else begin
            strb.loadRemHdr = 1'b1;
            nextState = ST_RUN;
          end
        end
        ST_SUBCMD: begin
          strb.loadRemSub = 1'b1;
          nextState = subSizeZero ? ST_HEADER : ST_PAYLOAD;
        end
        ST_PAYLOAD: begin
          strb.decRem = 1'b1;
          if (remIsOne) nextState = ST_HEADER;
        end
        ST_RUN: begin
          strb.decRem = 1'b1;
          strb.emitSample = 1'b1;
          if (remIsOne) nextState = ST_HEADER;
        end
        default: nextState = ST_HEADER;
      endcase
    end
  end
endmodule

// File: rtl/ir_parse_dp.sv
module ir_parse_dp
  import ir_parse_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int PERIOD_US = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic [BYTE_W-1:0] inData,
  input  parseStrobes_t strb,
  output logic hdrIsRun,
  output logic hdrLenZero,
  output logic subSizeZero,
  output logic remIsOne,
  output logic evValid,
  output logic evPulse,
  output logic [DUR_W-1:0] evDuration,
  output logic evReset
);
  localparam int CNT_W = BYTE_W - 1;

  logic [BYTE_W-1:0] cmdReg;
  logic [LEN_W-1:0] remReg;
  logic [LEN_W-1:0] subLen;
  logic [DUR_W-1:0] sampleDur;

  assign subLen = payloadLen(cmdReg, inData);
  assign hdrIsRun = (inData[7:5] == RUN_FIELD) && (inData != CMD_HDR);
  assign hdrLenZero = (inData[LEN_W-1:0] == '0);
  assign subSizeZero = (subLen == '0);
  assign remIsOne = (remReg == LEN_W'(1));
  assign sampleDur = DUR_W'(inData[CNT_W-1:0]) * DUR_W'(PERIOD_US);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      remReg <= '0;
    end else begin
      if (strb.loadCmd) cmdReg <= inData;
      if (strb.loadRemHdr) remReg <= inData[LEN_W-1:0];
      else if (strb.loadRemSub) remReg <= subLen;
      else if (strb.decRem) remReg <= remReg - LEN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evValid <= 1'b0;
      evPulse <= 1'b0;
      evDuration <= '0;
      evReset <= 1'b0;
    end else begin
      evValid <= strb.emitSample;
      evReset <= strb.emitReset;
      if (strb.emitSample) begin
        evPulse <= inData[BYTE_W-1];
        evDuration <= sampleDur;
      end
    end
  end
endmodule

// File: rtl/ir_packet_parser.sv
module ir_packet_parser
  import ir_parse_pkg::*;
#(
  parameter int DUR_W = 16,
  parameter int PERIOD_US = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [7:0] inData,
  output logic inReady,
  output logic evValid,
  output logic evPulse,
  output logic [DUR_W-1:0] evDuration,
  output logic evReset
);
  parseStrobes_t strb;
  logic hdrIsRun, hdrLenZero, subSizeZero, remIsOne;

  ir_parse_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .hdrIsRun(hdrIsRun), .hdrLenZero(hdrLenZero),
    .subSizeZero(subSizeZero), .remIsOne(remIsOne),
    .inReady(inReady), .strb(strb)
  );

  ir_parse_dp #(.DUR_W(DUR_W), .PERIOD_US(PERIOD_US)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strb(strb),
    .hdrIsRun(hdrIsRun), .hdrLenZero(hdrLenZero),
    .subSizeZero(subSizeZero), .remIsOne(remIsOne),
    .evValid(evValid), .evPulse(evPulse),
    .evDuration(evDuration), .evReset(evReset)
  );
endmodule

// File: rtl/ir_packet_parser_chk.sv
module ir_packet_parser_chk #(
  parameter int DUR_W = 16,
  parameter int PERIOD_US = 50
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic [7:0] inData,
  input logic inReady,
  input logic evValid,
  input logic evPulse,
  input logic [DUR_W-1:0] evDuration,
  input logic evReset
);
  assert_ready_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReady);

  assert_sample_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    evValid |-> (evPulse == $past(inData[7])) &&
                (evDuration == DUR_W'($past(inData[6:0])) * DUR_W'(PERIOD_US)));

  assert_reset_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    evReset |-> ($past(inData) == 8'hA0));

  assert_one_event_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evValid, evReset}));

  assert_event_needs_byte_R10: assert property (@(posedge clk) disable iff (!rstN)
    (evValid || evReset) |-> $past(inValid && inReady));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !evValid && !evReset);
endmodule

bind ir_packet_parser ir_packet_parser_chk #(.DUR_W(DUR_W), .PERIOD_US(PERIOD_US)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
  .evValid(evValid), .evPulse(evPulse), .evDuration(evDuration), .evReset(evReset)
);

// File: tb/test_ir_packet_parser.sv
module test_ir_packet_parser;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inReady, evValid, evPulse, evReset;
  logic [15:0] evDuration;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state: 0 header, 1 subcommand, 2 payload, 3 run
  int mState = 0;
  logic [7:0] mCmd = 8'h00;
  int mRem = 0;

  always #10 clk = ~clk;

  ir_packet_parser i_ir_packet_parser (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inReady(inReady),
    .evValid(evValid), .evPulse(evPulse), .evDuration(evDuration), .evReset(evReset)
  );

  function automatic int sizeOf(logic [7:0] c, logic [7:0] s);
    if (c == 8'h00 && s == 8'hFF) return 1;
    if (c == 8'hFF && s == 8'h0B) return 2;
    if (c == 8'h9F && (s == 8'h06 || s == 8'h0C || s == 8'h15)) return 2;
    if (c == 8'h9F && (s == 8'h01 || s == 8'h08 || s == 8'h14)) return 1;
    return 0;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // drive one cycle, predict, compare after the edge (R10 is covered by the event compares)
  task automatic step(logic [7:0] b, bit v);
    bit eV = 0, eP = 0, eR = 0;
    int eD = 0;
    string tag = "R9";
    if (v) begin
      case (mState)
        0: begin
          if (b == 8'h9F || b[7:5] != 3'b101) begin
            mCmd = b; mState = 1; tag = "R5";
          end else begin
            mRem = int'(b[4:0]);
            if (mRem != 0) begin mState = 3; tag = "R2"; end
            else begin eR = 1; tag = "R4"; end
          end
        end
        1: begin
          mRem = sizeOf(mCmd, b);
          mState = (mRem == 0) ? 0 : 2;
          tag = (mRem == 0) ? "R8" : "R6";
        end
        2: begin
          mRem--; if (mRem == 0) mState = 0; tag = "R7";
        end
        default: begin
          mRem--; if (mRem == 0) mState = 0;
          eV = 1; eP = b[7]; eD = int'(b[6:0]) * 50; tag = "R3";
        end
      endcase
    end
    inData = b;
    inValid = v;
    @(posedge clk);
    @(negedge clk);
    check(tag, "evValid", int'(evValid), int'(eV));
    check(tag, "evReset", int'(evReset), int'(eR));
    if (eV) begin
      check(tag, "evPulse", int'(evPulse), int'(eP));
      check(tag, "evDuration", int'(evDuration), eD);
    end
    inValid = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] b);
    step(b, 1'b1);
  endtask

  task automatic randPacket();
    int kind = int'($urandom % 6);
    int n;
    logic [7:0] subs [7] = '{8'h06, 8'h0C, 8'h15, 8'h01, 8'h08, 8'h14, 8'h33};
    if ($urandom % 3 == 0) step(8'($urandom), 1'b0);
    case (kind)
      0, 1: begin
        n = int'($urandom % 32);
        sendByte(8'hA0 | 8'(n));
        for (int i = 0; i < n; i++) begin
          if ($urandom % 5 == 0) step(8'($urandom), 1'b0);
          sendByte(8'($urandom));
        end
      end
      2: begin
        sendByte(8'h9F);
        sendByte(subs[$urandom % 7]);
        for (int i = 0; i < 2; i++) sendByte(8'($urandom));
      end
      3: begin sendByte(8'h00); sendByte(8'hFF); sendByte(8'($urandom)); end
      4: begin sendByte(8'hFF); sendByte(8'h0B); sendByte(8'($urandom)); sendByte(8'($urandom)); end
      default: sendByte(8'($urandom));
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "inReady in reset", int'(inReady), 0);
    check("R1", "evValid in reset", int'(evValid), 0);
    check("R1", "evReset in reset", int'(evReset), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "inReady after reset", int'(inReady), 1);

    // R4: zero-length run gives reset event, stays in header
    sendByte(8'hA0);
    sendByte(8'hA0);
    // R2/R3: run of two samples, pulse then space, extremes of count
    sendByte(8'hA2); sendByte(8'hFF); sendByte(8'h00);
    // R5/R6/R7: command header with 2-byte payload that looks like samples
    sendByte(8'h9F); sendByte(8'h06); sendByte(8'hA0); sendByte(8'h85);
    // 1-byte payload
    sendByte(8'h9F); sendByte(8'h08); sendByte(8'hA1);
    // null command + hardware header subcommand, then hardware header + revision
    sendByte(8'h00); sendByte(8'hFF); sendByte(8'hA0);
    sendByte(8'hFF); sendByte(8'h0B); sendByte(8'hA3); sendByte(8'hA0);
    // R8: unknown subcommand, size 0, next byte is header
    sendByte(8'h40); sendByte(8'h77); sendByte(8'hA0);
    sendByte(8'h9F); sendByte(8'hA0); sendByte(8'hA1); sendByte(8'h81);
    // R9: idle cycles in the middle of a run do not count
    sendByte(8'hA3); sendByte(8'h91);
    step(8'hA0, 1'b0); step(8'h00, 1'b0);
    sendByte(8'h12); sendByte(8'h7F); sendByte(8'hA0);
    // R2: longest run
    sendByte(8'hBF);
    for (int i = 0; i < 31; i++) sendByte(8'(i * 9));
    sendByte(8'hA0);
    // random mixed stream
    for (int p = 0; p < 3000; p++) randPacket();
    finishRun();
  end
endmodule